// File: doc/BRIEF.md
# Register-Programmed Countdown Timer

This block is a 32-bit timer that counts down. Software sets it up through eight word registers on a simple synchronous bus. While the timer is stopped, software selects full-width operation, picks single-shot or repeating mode and writes a start value. It then sets the run bit. The counter steps down by one on every clock.

When the count has been zero for one cycle, the timer records a timeout in a sticky status flag. If the matching mask bit is set, the timeout also drives the interrupt line high. Software clears the flag by writing a one to the acknowledge register.

In single-shot mode the run bit drops by itself at the timeout. In repeating mode the counter reloads from the start value and keeps going. While the timer runs, the settings are locked: writes to the width, mode and start-value registers are dropped.

Top module: `countdown_timer`

## Requirements
- R1: Registers sit at word indices 0 RUN (bit 0 is the run bit), 1 WIDTH (bits 2:0), 2 MODE (bits 1:0), 3 START (32 bits), 4 MASK (bit 0), 5 FLAG (bit 0, read-only), 6 MFLAG (bit 0, read-only) and 7 ACK (write-only, reads 0). After reset every register reads 0 and `irq` is low.
- R2: Writing 1 to the RUN bit while it is 0 loads the START value L into the counter. FLAG becomes 1 exactly L+1 clock edges after the edge that took the write.
- R3: With MODE = 1 (single-shot), the RUN bit reads 0 after the timeout. No further timeout follows.
- R4: With MODE = 2 (repeating), the counter reloads from START at each timeout. Timeouts follow every L+1 cycles.
- R5: The counter runs only when WIDTH = 0 and MODE is 1 or 2. With any other WIDTH or MODE value, no timeout ever occurs.
- R6: While the RUN bit is 1, writes to WIDTH, MODE and START are ignored. While it is 0, they take effect.
- R7: FLAG is set on a timeout whatever MASK holds. MFLAG reads FLAG AND MASK, and `irq` equals MFLAG.
- R8: Writing to ACK with bit 0 = 1 clears FLAG. Writing 0 leaves FLAG unchanged.
- R9: If a timeout and an ACK clear fall on the same clock edge, FLAG stays 1.
- R10: Writing 0 to RUN freezes the counter, so no timeout occurs. Writing 1 again reloads from START, and the timeout comes L+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Transfer request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read request |
| irq | output | 1 | Masked timeout interrupt |

## Verification
The assertions assume that each bus transfer lasts one cycle and that the bus is held idle between transfers. They also assume the address and write data are never unknown while `bus_sel` is high. The stimulus issues transfers only on falling clock edges, one transfer per cycle, and always addresses one of the eight defined indices. The bench deliberately tries to change the settings while the timer runs. This exercises the lock instead of steering around it, so the lock-related assertions see both blocked and accepted writes.

// File: rtl/tmr_pkg.sv
// Package: shared register indices and mode encodings for the countdown timer.
// Assumes an eight-entry word-indexed register space.
package tmr_pkg;

    localparam int unsigned REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        RA_RUN   = 3'd0,
        RA_WIDTH = 3'd1,
        RA_MODE  = 3'd2,
        RA_START = 3'd3,
        RA_MASK  = 3'd4,
        RA_FLAG  = 3'd5,
        RA_MFLAG = 3'd6,
        RA_ACK   = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        MODE_IDLE     = 2'd0,
        MODE_ONESHOT  = 2'd1,
        MODE_REPEAT   = 2'd2,
        MODE_RESERVED = 2'd3
    } mode_e;

endpackage

// File: rtl/tmr_regs.sv
// Module: register file and bus decode for the countdown timer.
// Holds run, width, mode, start value and mask. The settings are locked
// while the run bit is set. Reads are combinational, writes land on the
// next rising edge. Assumes single-cycle transfers.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned WIDTH_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    input  logic              oneshot_done,
    output logic [DATA_W-1:0] rdata,
    output logic              run,
    output logic              start,
    output logic              run_ok,
    output logic              repeating,
    output logic [DATA_W-1:0] start_val,
    output logic              mask,
    output logic              ack_clr
);

    localparam logic [WIDTH_W-1:0] WIDTH_FULL = '0;

    logic               in_range;
    reg_idx_e           idx;
    logic               wr_hit;
    logic               rd_hit;
    logic               run_wr, width_wr, mode_wr, start_wr, mask_wr, ack_wr;
    logic [WIDTH_W-1:0] width_q;
    mode_e              mode_q;

    // Decode the address into a register index and check that it is in range.
    always_comb begin
        in_range = ((addr >> REG_IDX_W) == '0);
        idx      = reg_idx_e'(addr[REG_IDX_W-1:0]);
        wr_hit   = sel & wr & in_range;
        rd_hit   = sel & ~wr & in_range;
    end

    // Produce one write strobe per register.
    always_comb begin
        run_wr   = wr_hit && (idx == RA_RUN);
        width_wr = wr_hit && (idx == RA_WIDTH);
        mode_wr  = wr_hit && (idx == RA_MODE);
        start_wr = wr_hit && (idx == RA_START);
        mask_wr  = wr_hit && (idx == RA_MASK);
        ack_wr   = wr_hit && (idx == RA_ACK);
    end

    // Run bit: a single-shot timeout clears it, otherwise software sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (oneshot_done) begin
            run <= 1'b0;
        end else if (run_wr) begin
            run <= wdata[0];
        end
    end

    // Settings registers: written only while the timer is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q   <= '0;
            mode_q    <= MODE_IDLE;
            start_val <= '0;
        end else if (!run) begin
            if (width_wr) width_q   <= wdata[WIDTH_W-1:0];
            if (mode_wr)  mode_q    <= mode_e'(wdata[1:0]);
            if (start_wr) start_val <= wdata;
        end
    end

    // Mask register: writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= 1'b0;
        end else if (mask_wr) begin
            mask <= wdata[0];
        end
    end

    // Control pulses and decoded settings for the counter and the flag.
    always_comb begin
        start     = run_wr & wdata[0] & ~run;
        ack_clr   = ack_wr & wdata[0];
        run_ok    = (width_q == WIDTH_FULL) &&
                    ((mode_q == MODE_ONESHOT) || (mode_q == MODE_REPEAT));
        repeating = (mode_q == MODE_REPEAT);
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            case (idx)
                RA_RUN:   rdata[0] = run;
                RA_WIDTH: rdata[WIDTH_W-1:0] = width_q;
                RA_MODE:  rdata[1:0] = mode_q;
                RA_START: rdata = start_val;
                RA_MASK:  rdata[0] = mask;
                RA_FLAG:  rdata[0] = flag;
                RA_MFLAG: rdata[0] = flag & mask;
                RA_ACK:   rdata = '0;
                default:  rdata = '0;
            endcase
        end
    end

    assert_run_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        oneshot_done |=> !run);

    assert_start_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start_wr) |=> $stable(start_val));

    assert_mode_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode_wr) |=> $stable(mode_q));

endmodule

// File: rtl/tmr_down.sv
// Module: down-counter core. Loads on the start pulse and steps down
// while enabled. A zero count with the counter enabled is a timeout;
// repeating mode then reloads. Assumes the settings stay stable while
// run is high.
module tmr_down #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              start,
    input  logic              run_ok,
    input  logic              repeating,
    input  logic [DATA_W-1:0] start_val,
    output logic              tmo,
    output logic              oneshot_done
);

    logic [DATA_W-1:0] cnt_q;
    logic              active;
    logic              at_zero;

    // Detect a timeout: the counter is enabled and the count has reached zero.
    always_comb begin
        active       = run & run_ok;
        at_zero      = (cnt_q == '0);
        tmo          = active & at_zero;
        oneshot_done = tmo & ~repeating;
    end

    // Count register: load on start, reload or hold at zero, otherwise decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= start_val;
        end else if (active) begin
            if (at_zero) begin
                if (repeating) cnt_q <= start_val;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_restart_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == $past(start_val)));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && repeating) |=> (cnt_q == $past(start_val)));

    assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_flag.sv
// Module: sticky timeout flag with write-one-to-clear and masking.
// A timeout takes priority over a clear in the same cycle.
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tmo,
    input  logic ack_clr,
    input  logic mask,
    output logic flag,
    output logic irq
);

    // Flag register: set on a timeout, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (tmo) begin
            flag <= 1'b1;
        end else if (ack_clr) begin
            flag <= 1'b0;
        end
    end

    // Interrupt line: the flag gated by the mask.
    always_comb irq = flag & mask;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> flag);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && !tmo) |=> !flag);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmo && !ack_clr) |=> $stable(flag));

endmodule

// File: rtl/countdown_timer.sv
// Module: top level of the register-programmed countdown timer.
// Connects the register file, the down-counter and the timeout flag.
// Assumes a single-cycle synchronous register bus.
module countdown_timer
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = REG_IDX_W,
    parameter int unsigned WIDTH_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic              run, start, run_ok, repeating, mask, ack_clr;
    logic              tmo, oneshot_done, flag;
    logic [DATA_W-1:0] start_val;

    tmr_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .WIDTH_W(WIDTH_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (bus_sel),
        .wr          (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .flag        (flag),
        .oneshot_done(oneshot_done),
        .rdata       (bus_rdata),
        .run         (run),
        .start       (start),
        .run_ok      (run_ok),
        .repeating   (repeating),
        .start_val   (start_val),
        .mask        (mask),
        .ack_clr     (ack_clr)
    );

    tmr_down #(
        .DATA_W(DATA_W)
    ) u_down (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .start       (start),
        .run_ok      (run_ok),
        .repeating   (repeating),
        .start_val   (start_val),
        .tmo         (tmo),
        .oneshot_done(oneshot_done)
    );

    tmr_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .tmo    (tmo),
        .ack_clr(ack_clr),
        .mask   (mask),
        .flag   (flag),
        .irq    (irq)
    );

    assert_no_tmo_when_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> $stable(flag) || !flag);

endmodule

// File: tb/countdown_timer_test.sv
`timescale 1ns/1ps
module countdown_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    countdown_timer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Caller sits just after a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_irq(input int limit, output int pos);
        int j;
        pos = 0;
        j = 0;
        while (pos == 0 && j < limit) begin
            @(negedge clk);
            j++;
            if (irq) pos = j;
        end
    endtask

    task automatic setup(input logic [1:0] m, input logic [31:0] l);
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd2, {30'd0, m});
        wr(3'd3, l);
        wr(3'd4, 32'd1);
        wr(3'd7, 32'd1);
    endtask

    initial begin
        logic [31:0] v;
        int p;
        int q;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            chk("R1 reset register", v, 32'd0);
        end
        chk("R1 reset irq", {31'd0, irq}, 32'd0);

        // R2 / R3: single-shot sweep over start values
        for (int l = 0; l <= 8; l++) begin
            setup(2'd1, l);
            wr(3'd0, 32'd1);
            wait_irq(l + 5, p);
            chk("R2 timeout cycle", p, l + 1);
            rd(3'd0, v);
            chk("R3 run bit cleared", v, 32'd0);
            wr(3'd7, 32'd1);
            repeat (2 * l + 4) @(negedge clk);
            chk("R3 no second timeout", {31'd0, irq}, 32'd0);
        end

        // R4: repeating sweep
        for (int l = 1; l <= 8; l++) begin
            setup(2'd2, l);
            wr(3'd0, 32'd1);
            wait_irq(l + 5, p);
            chk("R4 first timeout", p, l + 1);
            wr(3'd7, 32'd1);
            if (irq) begin
                q = l + 2;
            end else begin
                wait_irq(l + 5, p);
                q = (p == 0) ? 0 : l + 2 + p;
            end
            chk("R4 second timeout", q, 2 * l + 2);
            wr(3'd0, 32'd0);
        end

        // R5: every width/mode combination
        for (int c = 0; c < 2; c++) begin
            for (int m = 0; m < 4; m++) begin
                setup(m[1:0], 32'd2);
                wr(3'd1, c);
                wr(3'd0, 32'd1);
                repeat (6) @(negedge clk);
                chk("R5 runs only when valid", {31'd0, irq},
                    {31'd0, (c == 0 && (m == 1 || m == 2))});
                wr(3'd0, 32'd0);
            end
        end

        // R6: settings locked while running
        setup(2'd2, 32'd20);
        wr(3'd0, 32'd1);
        wr(3'd3, 32'd3);
        rd(3'd3, v);
        chk("R6 start locked", v, 32'd20);
        wr(3'd2, 32'd1);
        rd(3'd2, v);
        chk("R6 mode locked", v, 32'd2);
        wr(3'd1, 32'd5);
        rd(3'd1, v);
        chk("R6 width locked", v, 32'd0);
        wr(3'd0, 32'd0);
        wr(3'd3, 32'd3);
        rd(3'd3, v);
        chk("R6 start accepted when stopped", v, 32'd3);

        // R7: flag independent of mask
        setup(2'd1, 32'd2);
        wr(3'd4, 32'd0);
        wr(3'd0, 32'd1);
        repeat (5) @(negedge clk);
        chk("R7 irq masked", {31'd0, irq}, 32'd0);
        rd(3'd5, v);
        chk("R7 flag set while masked", v, 32'd1);
        rd(3'd6, v);
        chk("R7 masked flag zero", v, 32'd0);
        wr(3'd4, 32'd1);
        chk("R7 irq after unmask", {31'd0, irq}, 32'd1);
        rd(3'd6, v);
        chk("R7 masked flag one", v, 32'd1);

        // R8: acknowledge behaviour
        wr(3'd7, 32'd0);
        rd(3'd5, v);
        chk("R8 zero write no effect", v, 32'd1);
        wr(3'd7, 32'd1);
        rd(3'd5, v);
        chk("R8 one write clears", v, 32'd0);
        chk("R8 irq low after clear", {31'd0, irq}, 32'd0);

        // R9: timeout and clear on the same edge
        setup(2'd1, 32'd3);
        wr(3'd0, 32'd1);
        repeat (3) @(negedge clk);
        wr(3'd7, 32'd1);
        rd(3'd5, v);
        chk("R9 single-shot collision", v, 32'd1);
        setup(2'd2, 32'd0);
        wr(3'd0, 32'd1);
        repeat (3) @(negedge clk);
        wr(3'd7, 32'd1);
        rd(3'd5, v);
        chk("R9 repeating collision", v, 32'd1);
        wr(3'd0, 32'd0);

        // R10: stop freezes, restart reloads
        setup(2'd1, 32'd6);
        wr(3'd0, 32'd1);
        repeat (3) @(negedge clk);
        wr(3'd0, 32'd0);
        repeat (12) @(negedge clk);
        chk("R10 frozen", {31'd0, irq}, 32'd0);
        wr(3'd0, 32'd1);
        wait_irq(12, p);
        chk("R10 restart timeout", p, 32'd7);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule